// File: doc/BRIEF.md
# Two-Stage Vector Funnel Shifter

This block shifts a 128-bit vector logically to the right or to the left by any distance from 0 to 127 bits. The shift is split into two cascaded stages. A byte crossbar first moves whole bytes, choosing a source byte for each destination lane. A sub-byte stage then finishes the job with a shift of 0 to 7 bits. Bits that the shift vacates are filled with zeros.

The distance is not a narrow operand. It is read from fixed positions inside a full-width control vector, so software can keep a shift control in an ordinary vector register. The vector's bits are numbered from the most significant end, so bit 0 is the MSB and bit 127 is the LSB. Under that numbering, bits 121 to 127 hold the count. Bits 121–124 are the byte count and bits 125–127 are the residual bit count. Every other control bit has no effect.

A valid strobe qualifies each input. The result is registered and appears one clock after the input, together with an output valid flag.

Top module: `vec_funnel_shifter`

## Requirements
- R1: With `in_left` = 0, the result equals `in_data` shifted right (towards the LSB) by the count, with zeros filling the vacated upper bits.
- R2: With `in_left` = 1, the result equals `in_data` shifted left (towards the MSB) by the count, with zeros filling the vacated lower bits.
- R3: The count comes from `in_ctrl[6:0]` in port indexing, which is bits 121–127 when bit 0 is the MSB. The byte count is `in_ctrl[6:3]` and the bit count is `in_ctrl[2:0]`, and the total distance is byte count × 8 + bit count. For example, a count of 7'b1111000 moves data by 120 bits.
- R4: Control bits `in_ctrl[127:7]` have no effect on the result.
- R5: A count of zero returns `in_data` unchanged in either direction.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_data` holds that input's result in the same cycle.
- R7: While `in_valid` is low, `out_data` keeps its last value.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero at the next clock edge.
- R9: The two stages compose. A count of 7'b0001011 (one byte plus three bits) shifts by exactly 11 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_data | input | 128 | Vector to shift |
| in_ctrl | input | 128 | Control vector; count in bits [6:0] |
| in_left | input | 1 | 1 = shift left, 0 = shift right |
| out_valid | output | 1 | Result valid, one cycle after input |
| out_data | output | 128 | Registered shift result |

## Verification
The bench builds the block with its default parameters: a 128-bit vector with 8-bit lanes, giving a 4-bit byte count and a 3-bit bit count. With these values, every byte count from 0 to 15 can be reached. The extremes of a 127-bit shift in both directions can also be reached, as can the case where a byte move and a bit move combine across a lane boundary. Junk placed in the ignored upper control bits exercises R4 against a reference that uses only the low seven bits.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int unsigned FSH_DATA_W = 128;
  localparam int unsigned FSH_LANE_W = 8;

  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } fsh_dir_e;
endpackage

// File: rtl/fsh_byte_xbar.sv
module fsh_byte_xbar #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W / LANE_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              left,
  output logic [DATA_W-1:0] dout
);
  localparam int NLANE = DATA_W / LANE_W;

  // One source selector per destination lane
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    int src;
    logic [LANE_W-1:0] pick;
    always_comb begin
      src  = left ? (k - int'(nbytes)) : (k + int'(nbytes));
      pick = '0;
      for (int j = 0; j < NLANE; j++) begin
        if (src == j) pick = din[j*LANE_W +: LANE_W];
      end
    end
    assign dout[k*LANE_W +: LANE_W] = pick;
  end
endmodule

// File: rtl/fsh_bit_stage.sv
module fsh_bit_stage #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned SUB_W  = 3
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SUB_W-1:0]  nbits,
  input  logic              left,
  output logic [DATA_W-1:0] dout
);
  localparam int STEPS = 1 << SUB_W;

  // Per-bit selector over the few sub-lane distances
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic sel;
    always_comb begin
      sel = 1'b0;
      for (int s = 0; s < STEPS; s++) begin
        if (int'(nbits) == s) begin
          if (left) begin
            if (b - s >= 0) sel = din[b - s];
          end else begin
            if (b + s < DATA_W) sel = din[b + s];
          end
        end
      end
    end
    assign dout[b] = sel;
  end
endmodule

// File: rtl/vec_funnel_shifter.sv
module vec_funnel_shifter
  import fsh_pkg::*;
#(
  parameter int unsigned DATA_W = FSH_DATA_W,
  parameter int unsigned LANE_W = FSH_LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] in_ctrl,
  input  logic              in_left,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned NLANE = DATA_W / LANE_W;
  localparam int unsigned CNT_W = $clog2(NLANE);
  localparam int unsigned SUB_W = $clog2(LANE_W);
  localparam int unsigned AMT_W = CNT_W + SUB_W;

  fsh_dir_e          dir;
  logic [CNT_W-1:0]  nbytes;
  logic [SUB_W-1:0]  nbits;
  logic [DATA_W-1:0] byte_moved;
  logic [DATA_W-1:0] shifted;
  logic              ctrl_unused;

  assign dir         = fsh_dir_e'(in_left);
  assign nbytes      = in_ctrl[AMT_W-1:SUB_W];
  assign nbits       = in_ctrl[SUB_W-1:0];
  assign ctrl_unused = ^in_ctrl[DATA_W-1:AMT_W];

  fsh_byte_xbar #(.DATA_W(DATA_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_xbar (
    .din    (in_data),
    .nbytes (nbytes),
    .left   (dir == DIR_LEFT),
    .dout   (byte_moved)
  );

  fsh_bit_stage #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_bits (
    .din   (byte_moved),
    .nbits (nbits),
    .left  (dir == DIR_LEFT),
    .dout  (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= shifted;
    end
  end
endmodule

// File: rtl/vec_funnel_shifter_chk.sv
module vec_funnel_shifter_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned AMT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W-1:0] in_ctrl,
  input logic              in_left,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] model;
  assign amt   = in_ctrl[AMT_W-1:0];
  assign model = in_left ? (in_data << amt) : (in_data >> amt);

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R1
  right_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_left) |=> out_data == $past(model));
  // R2
  left_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_left) |=> out_data == $past(model));
  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt == '0) |=> out_data == $past(in_data));
endmodule

bind vec_funnel_shifter vec_funnel_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl),
  .in_left(in_left), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_vec_funnel_shifter.sv
module sim_vec_funnel_shifter;
  localparam int W = 128;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] in_ctrl = '0;
  logic         in_left = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vec_funnel_shifter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .in_left(in_left), .out_valid(out_valid), .out_data(out_data)
  );

  localparam logic [W-1:0] TV_DATA [N] = '{
    128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0123456789ABCDEF_FEDCBA9876543210,
    {W{1'b1}}, {W{1'b1}},
    128'h1, 128'h8000_0000_0000_0000_0000_0000_0000_0000,
    128'hDEADBEEF_CAFEF00D_A5A5A5A5_5A5A5A5A, 128'hDEADBEEF_CAFEF00D_A5A5A5A5_5A5A5A5A,
    128'hF0F0_0F0F_1234_5678_9ABC_DEF0_1357_9BDF, 128'hF0F0_0F0F_1234_5678_9ABC_DEF0_1357_9BDF,
    128'h8000_0000_0000_0000_0000_0000_0000_0001, 128'h8000_0000_0000_0000_0000_0000_0000_0001
  };
  // Upper bits carry junk in several rows to exercise R4
  localparam logic [W-1:0] TV_CTRL [N] = '{
    128'd8, 128'd8,
    128'd13, 128'd13,
    128'd127, 128'd127,
    {121'h1_2345_6789_ABCD_EF01_2345_6789_ABCD, 7'd37},
    {121'h1_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 7'd37},
    128'd64, 128'd71,
    {121'h0_5555_0000_AAAA_0000_5555_0000_AAAA, 7'd1},
    {121'h0_5555_0000_AAAA_0000_5555_0000_AAAA, 7'd1}
  };
  localparam logic TV_LEFT [N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                                   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] d,
                                             input logic [W-1:0] c, input logic l);
    logic [6:0] a;
    a = c[6:0];
    return l ? (d << a) : (d >> a);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one input for one cycle; returns at the negedge after the capturing edge
  task automatic apply(input logic [W-1:0] d, input logic [W-1:0] c, input logic l);
    @(negedge clk);
    in_data  = d;
    in_ctrl  = c;
    in_left  = l;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check("R8 valid after reset", {127'b0, out_valid}, '0);
    check("R8 data after reset", out_data, '0);

    // Table walk: R1, R2, R4, R6, R7
    for (int i = 0; i < N; i++) begin
      apply(TV_DATA[i], TV_CTRL[i], TV_LEFT[i]);
      check("R6 valid high", {127'b0, out_valid}, 128'd1);
      check(TV_LEFT[i] ? "R2 left shift" : "R1 right shift",
            out_data, ref_shift(TV_DATA[i], TV_CTRL[i], TV_LEFT[i]));
      held = out_data;
      in_data = ~in_data;
      in_ctrl = in_ctrl + 128'd5;
      @(negedge clk);
      check("R6 valid low", {127'b0, out_valid}, '0);
      check("R7 hold", out_data, held);
    end

    // R4: junk upper bits versus clean control give identical results
    apply(TV_DATA[6], {121'h0, 7'd37}, 1'b0);
    held = out_data;
    apply(TV_DATA[6], {121'h1_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 7'd37}, 1'b0);
    check("R4 upper control ignored", out_data, held);

    // R5: zero count with junk in the upper bits
    apply(TV_DATA[0], {121'h1_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F, 7'd0}, 1'b0);
    check("R5 zero count right", out_data, TV_DATA[0]);
    apply(TV_DATA[8], 128'h8000_0000_0000_0000_0000_0000_0000_0000, 1'b1);
    check("R5 zero count left", out_data, TV_DATA[8]);

    // R3: field positions, byte field [6:3], bit field [2:0]
    apply(128'h8000_0000_0000_0000_0000_0000_0000_0000, {121'h0, 7'b1111000}, 1'b0);
    check("R3 byte field 15 lanes", out_data, 128'h80);
    apply(128'h1, {121'h0, 7'b0000111}, 1'b1);
    check("R3 bit field 7", out_data, 128'h80);

    // R9: one byte plus three bits is 11 bits
    apply({W{1'b1}}, {121'h0, 7'b0001011}, 1'b0);
    check("R9 right 11", out_data, {11'b0, {117{1'b1}}});
    apply({W{1'b1}}, {121'h0, 7'b0001011}, 1'b1);
    check("R9 left 11", out_data, {{117{1'b1}}, 11'b0});

    // R1/R2 extremes at 127
    apply({W{1'b1}}, 128'd127, 1'b0);
    check("R1 right 127", out_data, 128'h1);
    apply({W{1'b1}}, 128'd127, 1'b1);
    check("R2 left 127", out_data, 128'h8000_0000_0000_0000_0000_0000_0000_0000);

    // R8: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 valid after mid reset", {127'b0, out_valid}, '0);
    check("R8 data after mid reset", out_data, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule